// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This block watches 32 general-purpose input pins and turns activity on them into interrupt requests. Each pin has its own configuration. It can be level sensitive, either active high or active low, or edge sensitive, on rising edges, falling edges or both. The detected condition is either held in a status bit until software clears it, or passed straight through so that the status bit follows the live condition. A single interrupt line goes out when any pin has both its status bit and its enable bit set.

Software reaches the block through a flat 16-bit register port with a write strobe and a combinational read. Every per-pin register exists as a low bank and a high bank. The low bank covers pins 0 to 15 and the high bank covers pins 16 to 31. Pin data and pin direction live in other blocks.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held high, every register reads 0 and `irq_o` is 0.
- R2: Registers sit at byte offsets, with the low bank first and the high bank 2 bytes above it: status 0x08/0x0A, enable 0x0C/0x0E, mode 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling-edge select 0x20/0x22, rising-edge select 0x24/0x26. Pin n (n<16) is bit n of a low register, and pin 16+n is bit n of a high register. Every configuration register reads back the value last written to it.
- R3: Reads from any other offset return 0, and writes to any other offset change no register.
- R4: A pin whose mode bit is 0 is level sensitive. Its condition is the pin being high when the polarity bit is 1, or the pin being low when the polarity bit is 0.
- R5: A pin whose mode bit is 1 is edge sensitive. A rising edge counts when its rising select bit is 1, and a falling edge counts when its falling select bit is 1. With both select bits at 0, the pin never raises status.
- R6: When the hold bit is 1, a detected condition sets the status bit, and the bit stays set until a 1 is written to it. Writing 0 leaves it unchanged. If a clear and a new detection land on the same cycle, the bit ends up set.
- R7: When the hold bit is 0, the status bit follows the condition of the previous cycle. An edge therefore gives a status pulse one cycle long, and a write-one-to-clear has no effect while the condition persists.
- R8: `irq_o` is high exactly when some pin in either bank has both its status bit and its enable bit set. The enable bit does not stop the status bit from being set.
- R9: A change on a pin first shows in status after the third rising clock edge following the change: two synchroniser stages, then the status register.
- R10: Writing 1 to the status bit of a pin with no active condition leaves that bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | 32 | Raw, asynchronous pin levels |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 6 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench aims at the cycle where a clear and a new edge collide. A design that lets the clear win drops that interrupt. It checks the exact latency by sampling status one cycle before and on the cycle the change is due, which catches a missing or an extra synchroniser stage. The edge-only pins are driven with the wrong edge, and with no select bit at all, to expose a detector that ignores the select bits. The bench then confirms that a pass-through edge gives a pulse one cycle long and that a pass-through level cannot be cleared by software, so that a status path which always latches stands out. Writes to unmapped and odd offsets test whether the decoder is too loose and aliases a live register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NPINS      = 32;
    localparam int BANK_W     = 16;
    localparam int NBANK      = NPINS / BANK_W;
    localparam int BANK_IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int ADDR_W     = 6;

    // Base offsets of the low bank; the high bank sits 2 bytes above.
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_EN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_MODE = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_POL  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_HOLD = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_FALL = 6'h20;
    localparam logic [ADDR_W-1:0] OFF_RISE = 6'h24;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_EN,
        SEL_MODE,
        SEL_POL,
        SEL_HOLD,
        SEL_FALL,
        SEL_RISE
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e              sel;
        logic [BANK_IDX_W-1:0] bank;
    } reg_dec_t;

    // Per-pin configuration, one bit per pin in each field.
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] mode;   // 1 = edge, 0 = level
        logic [NPINS-1:0] pol;    // 1 = active high
        logic [NPINS-1:0] hold;   // 1 = latch status
        logic [NPINS-1:0] fall;
        logic [NPINS-1:0] rise;
    } irq_cfg_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t             d;
        logic [ADDR_W-1:0]    base;
        base   = {a[ADDR_W-1:2], 2'b00};
        d.bank = BANK_IDX_W'(a[1]);
        d.sel  = SEL_NONE;
        if (!a[0]) begin
            case (base)
                OFF_STAT: d.sel = SEL_STAT;
                OFF_EN:   d.sel = SEL_EN;
                OFF_MODE: d.sel = SEL_MODE;
                OFF_POL:  d.sel = SEL_POL;
                OFF_HOLD: d.sel = SEL_HOLD;
                OFF_FALL: d.sel = SEL_FALL;
                OFF_RISE: d.sel = SEL_RISE;
                default:  d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prv_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur_o = cur_q;
    assign prv_o = prv_q;
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_dec_t          dec,
    input  logic [BANK_W-1:0] wdata,
    output irq_cfg_t          cfg_o
);
    logic [NPINS-1:0] en_q, mode_q, pol_q, hold_q, fall_q, rise_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            hold_q <= '0;
            fall_q <= '0;
            rise_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBANK; b++) begin
                if (dec.bank == BANK_IDX_W'(b)) begin
                    case (dec.sel)
                        SEL_EN:   en_q[b*BANK_W +: BANK_W]   <= wdata;
                        SEL_MODE: mode_q[b*BANK_W +: BANK_W] <= wdata;
                        SEL_POL:  pol_q[b*BANK_W +: BANK_W]  <= wdata;
                        SEL_HOLD: hold_q[b*BANK_W +: BANK_W] <= wdata;
                        SEL_FALL: fall_q[b*BANK_W +: BANK_W] <= wdata;
                        SEL_RISE: rise_q[b*BANK_W +: BANK_W] <= wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        cfg_o.en   = en_q;
        cfg_o.mode = mode_q;
        cfg_o.pol  = pol_q;
        cfg_o.hold = hold_q;
        cfg_o.fall = fall_q;
        cfg_o.rise = rise_q;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prv_i,
    input  irq_cfg_t         cfg_i,
    output logic [NPINS-1:0] cond_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise_ev, fall_ev, lvl_act;
        assign rise_ev = cfg_i.rise[p] &  cur_i[p] & ~prv_i[p];
        assign fall_ev = cfg_i.fall[p] & ~cur_i[p] &  prv_i[p];
        assign lvl_act = ~(cur_i[p] ^ cfg_i.pol[p]);
        assign cond_o[p] = cfg_i.mode[p] ? (rise_ev | fall_ev) : lvl_act;
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] cond_i,
    input  logic [NPINS-1:0] hold_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] stat_o
);
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] held_nxt;

    // A new detection wins over a clear in the same cycle.
    assign held_nxt = (stat_q & ~clr_i) | cond_i;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (hold_i & held_nxt) | (~hold_i & cond_i);
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rdata,
    output logic              irq_o
);
    reg_dec_t         dec;
    irq_cfg_t         cfg_q;
    logic [NPINS-1:0] cur_s, prv_s, cond, clr_vec, status_q;
    logic [NPINS-1:0] rd_vec;

    assign dec = decode_addr(addr);

    gpio_irq_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (pin_i),
        .cur_o (cur_s),
        .prv_o (prv_s)
    );

    gpio_irq_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .dec   (dec),
        .wdata (wdata),
        .cfg_o (cfg_q)
    );

    gpio_irq_detect u_det (
        .cur_i  (cur_s),
        .prv_i  (prv_s),
        .cfg_i  (cfg_q),
        .cond_o (cond)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_clr
        assign clr_vec[b*BANK_W +: BANK_W] =
            (wr_en && dec.sel == SEL_STAT && dec.bank == BANK_IDX_W'(b)) ? wdata : '0;
    end

    gpio_irq_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond),
        .hold_i (cfg_q.hold),
        .clr_i  (clr_vec),
        .stat_o (status_q)
    );

    always_comb begin
        case (dec.sel)
            SEL_STAT: rd_vec = status_q;
            SEL_EN:   rd_vec = cfg_q.en;
            SEL_MODE: rd_vec = cfg_q.mode;
            SEL_POL:  rd_vec = cfg_q.pol;
            SEL_HOLD: rd_vec = cfg_q.hold;
            SEL_FALL: rd_vec = cfg_q.fall;
            SEL_RISE: rd_vec = cfg_q.rise;
            default:  rd_vec = '0;
        endcase
    end

    assign rdata = (dec.sel == SEL_NONE) ? '0 : rd_vec[dec.bank*BANK_W +: BANK_W];
    assign irq_o = |(status_q & cfg_q.en);
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [5:0]  addr,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        irq_o,
    input logic [31:0] stat,
    input logic [31:0] hold,
    input logic [31:0] mode,
    input logic [31:0] en,
    input logic [31:0] cur,
    input logic [31:0] prv
);
    logic        rst_d;
    logic [31:0] clr_w;
    logic        mapped;

    always_ff @(posedge clk) rst_d <= rst;

    always_comb begin
        clr_w = '0;
        if (wr_en && addr == 6'h08) clr_w[15:0]  = wdata;
        if (wr_en && addr == 6'h0A) clr_w[31:16] = wdata;
    end

    assign mapped = (addr == 6'h08) || (addr == 6'h0A) || (addr == 6'h0C) ||
                    (addr == 6'h0E) || (addr == 6'h10) || (addr == 6'h12) ||
                    (addr == 6'h14) || (addr == 6'h16) || (addr == 6'h18) ||
                    (addr == 6'h1A) || (addr == 6'h20) || (addr == 6'h22) ||
                    (addr == 6'h24) || (addr == 6'h26);

    always_comb begin
        if (rst_d == 1'b1) begin
            AST_RESET_CLEAR: assert (stat == '0 && !irq_o); // R1
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> rdata == 16'h0); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        en == '0 |-> !irq_o); // R8

    for (genvar i = 0; i < 32; i++) begin : g_bit
        AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
            hold[i] && stat[i] && !clr_w[i] |=> stat[i]); // R6

        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
            mode[i] && !stat[i] && (cur[i] == prv[i]) |=> !stat[i]); // R5
    end
endmodule

bind gpio_irq_unit gpio_irq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .irq_o (irq_o),
    .stat  (status_q),
    .hold  (cfg_q.hold),
    .mode  (cfg_q.mode),
    .en    (cfg_q.en),
    .cur   (cur_s),
    .prv   (prv_s)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pin_i = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    gpio_irq_unit dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural reference model, updated on every rising edge.
    logic [31:0] m_s1, m_cur, m_prv, m_stat, m_en, m_mode, m_pol, m_hold, m_fall, m_rise;
    logic [31:0] m_cond, m_clr;
    initial begin
        m_s1 = '0; m_cur = '0; m_prv = '0; m_stat = '0; m_en = '0;
        m_mode = '0; m_pol = '0; m_hold = '0; m_fall = '0; m_rise = '0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_cur = '0; m_prv = '0; m_stat = '0; m_en = '0;
            m_mode = '0; m_pol = '0; m_hold = '0; m_fall = '0; m_rise = '0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_mode[i])
                    m_cond[i] = (m_rise[i] && m_cur[i] && !m_prv[i]) ||
                                (m_fall[i] && !m_cur[i] && m_prv[i]);
                else
                    m_cond[i] = m_pol[i] ? m_cur[i] : !m_cur[i];
            end
            m_clr = '0;
            if (wr_en && addr == 6'h08) m_clr[15:0]  = wdata;
            if (wr_en && addr == 6'h0A) m_clr[31:16] = wdata;
            for (int i = 0; i < 32; i++)
                m_stat[i] = m_hold[i] ? ((m_stat[i] && !m_clr[i]) || m_cond[i]) : m_cond[i];
            if (wr_en) begin
                case (addr)
                    6'h0C: m_en[15:0]    = wdata;
                    6'h0E: m_en[31:16]   = wdata;
                    6'h10: m_mode[15:0]  = wdata;
                    6'h12: m_mode[31:16] = wdata;
                    6'h14: m_pol[15:0]   = wdata;
                    6'h16: m_pol[31:16]  = wdata;
                    6'h18: m_hold[15:0]  = wdata;
                    6'h1A: m_hold[31:16] = wdata;
                    6'h20: m_fall[15:0]  = wdata;
                    6'h22: m_fall[31:16] = wdata;
                    6'h24: m_rise[15:0]  = wdata;
                    6'h26: m_rise[31:16] = wdata;
                    default: ;
                endcase
            end
            m_prv = m_cur;
            m_cur = m_s1;
            m_s1  = pin_i;
        end
    end

    // Interrupt line compared with the model on every clock (R8).
    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if (irq_o !== |(m_stat & m_en)) begin
                bad++;
                $display("FAIL R8 model irq: actual=%0b expected=%0b at %0t",
                         irq_o, |(m_stat & m_en), $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_word(input logic [5:0] a, input logic [15:0] exp, input string tag);
        addr = a; #1;
        total++;
        if (rdata !== exp) begin
            bad++;
            $display("FAIL %s @0x%02h: actual=%04h expected=%04h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_bit(input logic [5:0] a, input int b, input logic exp, input string tag);
        addr = a; #1;
        total++;
        if (rdata[b] !== exp) begin
            bad++;
            $display("FAIL %s @0x%02h bit%0d: actual=%0b expected=%0b", tag, a, b, rdata[b], exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        #1;
        total++;
        if (irq_o !== exp) begin
            bad++;
            $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq_o, exp);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        // R1: reset state
        chk_word(6'h08, 16'h0, "R1");
        chk_word(6'h0A, 16'h0, "R1");
        chk_word(6'h0C, 16'h0, "R1");
        chk_word(6'h10, 16'h0, "R1");
        chk_word(6'h24, 16'h0, "R1");
        chk_irq(1'b0, "R1");
        tick(1);
        rst = 1'b0;

        // R2: configuration and readback
        wr(6'h10, 16'h03E0);
        wr(6'h24, 16'h02A0);
        wr(6'h20, 16'h00C0);
        wr(6'h18, 16'h01E0);
        wr(6'h14, 16'h0008);
        wr(6'h0E, 16'hA5A5);
        chk_word(6'h10, 16'h03E0, "R2");
        chk_word(6'h24, 16'h02A0, "R2");
        chk_word(6'h20, 16'h00C0, "R2");
        chk_word(6'h18, 16'h01E0, "R2");
        chk_word(6'h14, 16'h0008, "R2");
        chk_word(6'h0E, 16'hA5A5, "R2");
        chk_word(6'h12, 16'h0000, "R2");
        tick(1);
        wr(6'h0E, 16'h0000);

        // R3: unmapped offsets
        wr(6'h00, 16'hFFFF);
        wr(6'h1C, 16'hFFFF);
        wr(6'h28, 16'hFFFF);
        wr(6'h11, 16'hFFFF);
        chk_word(6'h00, 16'h0, "R3");
        chk_word(6'h1C, 16'h0, "R3");
        chk_word(6'h28, 16'h0, "R3");
        chk_word(6'h11, 16'h0, "R3");
        chk_word(6'h10, 16'h03E0, "R3");
        chk_word(6'h0C, 16'h0000, "R3");
        chk_word(6'h0E, 16'h0000, "R3");
        tick(4);

        // R4 / R9: active-high level on pin 3
        pin_i[3] = 1'b1;
        tick(2);
        chk_bit(6'h08, 3, 1'b0, "R9");
        tick(1);
        chk_bit(6'h08, 3, 1'b1, "R4");
        wr(6'h08, 16'h0008);
        chk_bit(6'h08, 3, 1'b1, "R7");
        pin_i[3] = 1'b0;
        tick(3);
        chk_bit(6'h08, 3, 1'b0, "R4");

        // R2 / R4: pin 20 is bit 4 of the high bank, active low
        chk_bit(6'h0A, 4, 1'b1, "R2");
        pin_i[20] = 1'b1;
        tick(3);
        chk_bit(6'h0A, 4, 1'b0, "R4");
        pin_i[20] = 1'b0;
        tick(3);
        chk_bit(6'h0A, 4, 1'b1, "R4");

        // R5 / R6: rising only, held, on pin 5
        pin_i[5] = 1'b1;
        tick(3);
        chk_bit(6'h08, 5, 1'b1, "R5");
        tick(8);
        chk_bit(6'h08, 5, 1'b1, "R6");
        wr(6'h08, 16'h0000);
        chk_bit(6'h08, 5, 1'b1, "R6");
        wr(6'h08, 16'h0020);
        chk_bit(6'h08, 5, 1'b0, "R6");
        pin_i[5] = 1'b0;
        tick(4);
        chk_bit(6'h08, 5, 1'b0, "R5");

        // R5: falling only on pin 6
        pin_i[6] = 1'b1;
        tick(4);
        chk_bit(6'h08, 6, 1'b0, "R5");
        pin_i[6] = 1'b0;
        tick(3);
        chk_bit(6'h08, 6, 1'b1, "R5");
        wr(6'h08, 16'h0040);

        // R5: both edges on pin 7
        pin_i[7] = 1'b1;
        tick(3);
        chk_bit(6'h08, 7, 1'b1, "R5");
        wr(6'h08, 16'h0080);
        chk_bit(6'h08, 7, 1'b0, "R6");
        pin_i[7] = 1'b0;
        tick(3);
        chk_bit(6'h08, 7, 1'b1, "R5");
        wr(6'h08, 16'h0080);

        // R5: edge mode without select bits on pin 8
        pin_i[8] = 1'b1;
        tick(4);
        chk_bit(6'h08, 8, 1'b0, "R5");
        pin_i[8] = 1'b0;
        tick(4);
        chk_bit(6'h08, 8, 1'b0, "R5");

        // R10: writing 1 sets nothing
        wr(6'h08, 16'h0120);
        chk_bit(6'h08, 8, 1'b0, "R10");
        chk_bit(6'h08, 5, 1'b0, "R10");

        // R6: detection and clear on the same cycle, set wins
        pin_i[7] = 1'b1;
        tick(2);
        wr(6'h08, 16'h0080);
        chk_bit(6'h08, 7, 1'b1, "R6");

        // R7: pass-through edge on pin 9 is a single-cycle pulse
        pin_i[9] = 1'b1;
        tick(3);
        chk_bit(6'h08, 9, 1'b1, "R7");
        tick(1);
        chk_bit(6'h08, 9, 1'b0, "R7");

        // R8: enable masking, both banks
        pin_i[5] = 1'b1;
        tick(3);
        chk_bit(6'h08, 5, 1'b1, "R8");
        chk_irq(1'b0, "R8");
        wr(6'h0C, 16'h0020);
        chk_irq(1'b1, "R8");
        wr(6'h08, 16'h0020);
        chk_irq(1'b0, "R8");
        wr(6'h0C, 16'h0000);
        wr(6'h0E, 16'h0010);
        chk_irq(1'b1, "R8");
        wr(6'h0E, 16'h0000);
        chk_irq(1'b0, "R8");

        tick(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule